// File: doc/BRIEF.md
# Register-File Expression Evaluation Stack

This block is a small operand stack built from flip-flops, intended for evaluating arithmetic expressions without touching memory. A host issues one command per clock: push a short immediate, push a full-width data word, pop, peek, or apply one of three binary operators (add, subtract, multiply). Each operator consumes the two topmost entries in place and leaves its result as the new top, so an expression in postfix order reduces to a single value at the top.

The top of stack and the current depth are always visible on output ports. Pop and peek also present the top value on a registered output strobe, which is the path for handing a finished result to whatever performs the assignment. Any command that would overflow or underflow the stack is refused: the contents stay as they were and a one-cycle error flag is raised.

Top module: `expr_stack`

## Requirements
- R1: After reset, depth is 0, the top-of-stack output is 0, both error flags are low and the output strobe is low.
- R2: Opcode 1 pushes the IMM_W-bit immediate zero-extended to W bits; opcode 2 pushes the W-bit data word. Either raises depth by one, and the pushed value shows on the top-of-stack output in the cycle after the command.
- R3: A push when depth equals DEPTH raises the overflow flag for one cycle and changes neither depth nor any entry.
- R4: Opcode 3 (pop) with depth at least 1 asserts the output strobe for one cycle with the old top value and lowers depth by one.
- R5: Opcode 4 (peek) with depth at least 1 asserts the output strobe with the top value and leaves depth and the top unchanged.
- R6: Opcodes 5, 6 and 7 (add, subtract, multiply) with depth at least 2 replace the two top entries with one result, depth falling by one; the second entry is the left operand and the top entry the right, so subtract yields second minus top.
- R7: Arithmetic wraps modulo 2^W; multiply keeps the low W bits of the product.
- R8: A pop or peek at depth 0, or an operator at depth below 2, raises the underflow flag for one cycle and leaves depth, contents and the output strobe untouched.
- R9: A new command is accepted every cycle; with cmd_valid low, or with opcode 0, nothing changes and both flags and the strobe are low in the next cycle.
- R10: The sequence push 7, push 4, subtract, push 9, push 3, add, multiply leaves 36 as the only entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode (0 none, 1 push imm, 2 push data, 3 pop, 4 peek, 5 add, 6 sub, 7 mul) |
| cmd_imm | input | IMM_W | Immediate for opcode 1 |
| cmd_data | input | W | Data word for opcode 2 |
| tos_data | output | W | Current top entry, 0 when empty |
| depth | output | $clog2(DEPTH+1) | Number of entries held |
| ovf | output | 1 | One-cycle overflow flag |
| unf | output | 1 | One-cycle underflow flag |
| out_valid | output | 1 | Pop or peek result strobe |
| out_data | output | W | Value delivered by pop or peek |

## Verification
The assertions assume the reset is held long enough for the first clock edge to see a cleared stack and that cmd_op is always a defined 3-bit value while cmd_valid is high. They also rely on the inputs being stable around the rising edge, which the stimulus ensures by changing every input only on the falling edge. The random mix biases toward pushes at low depth and toward pops and operators near full depth, so both refusal paths and the full range of depths are reached, while directed sequences cover the worked expression, wrap-around and the immediate zero-extension.

// File: rtl/expr_stack_pkg.sv
package expr_stack_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSHI = 3'd1,
    OP_PUSHD = 3'd2,
    OP_POP   = 3'd3,
    OP_PEEK  = 3'd4,
    OP_ADD   = 3'd5,
    OP_SUB   = 3'd6,
    OP_MUL   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    WSRC_IMM  = 2'd0,
    WSRC_DATA = 2'd1,
    WSRC_ALU  = 2'd2
  } wsrc_e;
endpackage

// File: rtl/es_regfile.sv
module es_regfile #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [IDX_W-1:0] rd_idx_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [W-1:0]     rd_a,
  output logic [W-1:0]     rd_b
);
  logic [W-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic         ce;
    logic [W-1:0] ent_d;
    always_comb begin
      ce    = wr_en && (wr_idx == IDX_W'(g));
      ent_d = ce ? wr_data : ent_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[g] <= '0;
      else        ent_q[g] <= ent_d;
    end
  end

  always_comb begin
    rd_a = '0;
    rd_b = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx_a == IDX_W'(i)) rd_a = ent_q[i];
      if (rd_idx_b == IDX_W'(i)) rd_b = ent_q[i];
    end
  end
endmodule

// File: rtl/es_alu.sv
module es_alu
  import expr_stack_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res
);
  logic [2*W-1:0] prod;

  always_comb begin
    prod = lhs * rhs;
    unique case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_MUL:  res = prod[W-1:0];
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/es_ctrl.sv
module es_ctrl
  import expr_stack_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  op_e              op,
  input  logic [W-1:0]     top_val,
  output logic [CNT_W-1:0] depth_q,
  output logic [IDX_W-1:0] idx_top,
  output logic [IDX_W-1:0] idx_sec,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output wsrc_e            wr_src,
  output logic             ovf_q,
  output logic             unf_q,
  output logic             outv_q,
  output logic [W-1:0]     outd_q
);
  logic [CNT_W-1:0] depth_d, dm1, dm2;
  logic             ovf_d, unf_d, outv_d, outd_ce;
  logic             has1, has2, full;

  always_comb begin
    dm1     = depth_q - CNT_W'(1);
    dm2     = depth_q - CNT_W'(2);
    idx_top = dm1[IDX_W-1:0];
    idx_sec = dm2[IDX_W-1:0];
    has1    = depth_q >= CNT_W'(1);
    has2    = depth_q >= CNT_W'(2);
    full    = depth_q == CNT_W'(DEPTH);

    depth_d = depth_q;
    ovf_d   = 1'b0;
    unf_d   = 1'b0;
    outv_d  = 1'b0;
    outd_ce = 1'b0;
    wr_en   = 1'b0;
    wr_idx  = depth_q[IDX_W-1:0];
    wr_src  = WSRC_ALU;

    if (cmd_valid) begin
      unique case (op)
        OP_PUSHI, OP_PUSHD: begin
          if (full) ovf_d = 1'b1;
          else begin
            wr_en   = 1'b1;
            wr_src  = (op == OP_PUSHI) ? WSRC_IMM : WSRC_DATA;
            depth_d = depth_q + CNT_W'(1);
          end
        end
        OP_POP, OP_PEEK: begin
          if (!has1) unf_d = 1'b1;
          else begin
            outv_d  = 1'b1;
            outd_ce = 1'b1;
            if (op == OP_POP) depth_d = dm1;
          end
        end
        OP_ADD, OP_SUB, OP_MUL: begin
          if (!has2) unf_d = 1'b1;
          else begin
            wr_en   = 1'b1;
            wr_idx  = idx_sec;
            depth_d = dm1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      outv_q  <= 1'b0;
    end else begin
      depth_q <= depth_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
      outv_q  <= outv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       outd_q <= '0;
    else if (outd_ce) outd_q <= top_val;
  end
endmodule

// File: rtl/expr_stack.sv
module expr_stack
  import expr_stack_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int IMM_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [IMM_W-1:0] cmd_imm,
  input  logic [W-1:0]     cmd_data,
  output logic [W-1:0]     tos_data,
  output logic [CNT_W-1:0] depth,
  output logic             ovf,
  output logic             unf,
  output logic             out_valid,
  output logic [W-1:0]     out_data
);
  op_e              op;
  logic [IDX_W-1:0] idx_top, idx_sec, wr_idx;
  logic             wr_en;
  wsrc_e            wr_src;
  logic [W-1:0]     top_val, sec_val, alu_res, wr_data;
  logic [CNT_W-1:0] depth_q;

  assign op = op_e'(cmd_op);

  es_ctrl #(.W(W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .op(op),
    .top_val(top_val), .depth_q(depth_q), .idx_top(idx_top),
    .idx_sec(idx_sec), .wr_en(wr_en), .wr_idx(wr_idx), .wr_src(wr_src),
    .ovf_q(ovf), .unf_q(unf), .outv_q(out_valid), .outd_q(out_data)
  );

  es_alu #(.W(W)) u_alu (
    .op(op), .lhs(sec_val), .rhs(top_val), .res(alu_res)
  );

  always_comb begin
    unique case (wr_src)
      WSRC_IMM:  wr_data = W'(cmd_imm);
      WSRC_DATA: wr_data = cmd_data;
      default:   wr_data = alu_res;
    endcase
  end

  es_regfile #(.W(W), .DEPTH(DEPTH)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx_a(idx_top), .rd_idx_b(idx_sec),
    .rd_a(top_val), .rd_b(sec_val)
  );

  assign depth    = depth_q;
  assign tos_data = (depth_q == '0) ? '0 : top_val;
endmodule

// File: rtl/expr_stack_chk.sv
module expr_stack_chk #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int IMM_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic [IMM_W-1:0] cmd_imm,
  input logic [W-1:0]     cmd_data,
  input logic [W-1:0]     tos_data,
  input logic [CNT_W-1:0] depth,
  input logic             ovf,
  input logic             unf,
  input logic             out_valid,
  input logic [W-1:0]     out_data
);
  logic is_push, is_read, is_bin;
  assign is_push = cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2);
  assign is_read = cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4);
  assign is_bin  = cmd_valid && (cmd_op >= 3'd5);

  p_depth_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(DEPTH));

  p_pushd_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2 && depth < CNT_W'(DEPTH))
      |=> (tos_data == $past(cmd_data)) && (depth == $past(depth) + CNT_W'(1)));

  p_pushi_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1 && depth < CNT_W'(DEPTH))
      |=> tos_data == W'($past(cmd_imm)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_push && depth == CNT_W'(DEPTH))
      |=> ovf && $stable(depth) && $stable(tos_data));

  p_pop_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3 && depth != '0)
      |=> out_valid && out_data == $past(tos_data) && depth == $past(depth) - CNT_W'(1));

  p_peek_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd4 && depth != '0)
      |=> out_valid && out_data == $past(tos_data) && $stable(depth) && $stable(tos_data));

  p_bin_depth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_bin && depth >= CNT_W'(2)) |=> depth == $past(depth) - CNT_W'(1));

  p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_read && depth == '0) || (is_bin && depth < CNT_W'(2)))
      |=> unf && !out_valid && $stable(depth) && $stable(tos_data));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || cmd_op == 3'd0)
      |=> !ovf && !unf && !out_valid && $stable(depth) && $stable(tos_data));

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf, unf, out_valid}));
endmodule

bind expr_stack expr_stack_chk #(.W(W), .DEPTH(DEPTH), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/expr_stack_bench.sv
module expr_stack_bench;
  localparam int W     = 16;
  localparam int DEPTH = 8;
  localparam int IMM_W = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [2:0]       cmd_op = 3'd0;
  logic [IMM_W-1:0] cmd_imm = '0;
  logic [W-1:0]     cmd_data = '0;
  logic [W-1:0]     tos_data, out_data;
  logic [CNT_W-1:0] depth;
  logic             ovf, unf, out_valid;

  int checks = 0;
  int failures = 0;

  logic [W-1:0] m_ent [DEPTH];
  int           m_depth = 0;

  always #2 clk = ~clk;

  expr_stack #(.W(W), .DEPTH(DEPTH), .IMM_W(IMM_W)) u_expr_stack (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_imm(cmd_imm), .cmd_data(cmd_data), .tos_data(tos_data),
    .depth(depth), .ovf(ovf), .unf(unf), .out_valid(out_valid),
    .out_data(out_data)
  );

  function automatic logic [W-1:0] f_apply(input logic [2:0] op,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    logic [2*W-1:0] p;
    p = a * b;
    case (op)
      3'd5: return a + b;
      3'd6: return a - b;
      default: return p[W-1:0];
    endcase
  endfunction

  function automatic string f_req(input logic valid, input logic [2:0] op);
    if (!valid || op == 3'd0) return "R9";
    case (op)
      3'd1, 3'd2: return "R2/R3";
      3'd3:       return "R4/R8";
      3'd4:       return "R5/R8";
      default:    return "R6/R7/R8";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op,
                      input logic [IMM_W-1:0] imm, input logic [W-1:0] dat,
                      input string req_override);
    logic [W-1:0] e_tos, e_od;
    logic         e_ovf, e_unf, e_ov;
    string        req;
    e_ovf = 0; e_unf = 0; e_ov = 0; e_od = 'x;
    if (v) begin
      case (op)
        3'd1, 3'd2: begin
          if (m_depth == DEPTH) e_ovf = 1;
          else begin
            m_ent[m_depth] = (op == 3'd1) ? W'(imm) : dat;
            m_depth++;
          end
        end
        3'd3, 3'd4: begin
          if (m_depth == 0) e_unf = 1;
          else begin
            e_ov = 1;
            e_od = m_ent[m_depth-1];
            if (op == 3'd3) m_depth--;
          end
        end
        3'd5, 3'd6, 3'd7: begin
          if (m_depth < 2) e_unf = 1;
          else begin
            m_ent[m_depth-2] = f_apply(op, m_ent[m_depth-2], m_ent[m_depth-1]);
            m_depth--;
          end
        end
        default: ;
      endcase
    end
    e_tos = (m_depth == 0) ? '0 : m_ent[m_depth-1];
    req = (req_override != "") ? req_override : f_req(v, op);

    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_imm = imm; cmd_data = dat;
    @(posedge clk);
    #1;
    chk(req, "depth", W'(depth), W'(m_depth));
    chk(req, "tos", tos_data, e_tos);
    chk(req, "ovf", W'(ovf), W'(e_ovf));
    chk(req, "unf", W'(unf), W'(e_unf));
    chk(req, "out_valid", W'(out_valid), W'(e_ov));
    if (e_ov) chk(req, "out_data", out_data, e_od);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "depth", W'(depth), '0);
    chk("R1", "tos", tos_data, '0);
    chk("R1", "flags", W'({ovf, unf, out_valid}), '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10 worked expression
    step(1, 3'd1, 8'd7, '0, "R10");
    step(1, 3'd1, 8'd4, '0, "R10");
    step(1, 3'd6, '0, '0, "R10");
    chk("R10", "sub result", tos_data, 16'd3);
    step(1, 3'd1, 8'd9, '0, "R10");
    step(1, 3'd1, 8'd3, '0, "R10");
    step(1, 3'd5, '0, '0, "R10");
    step(1, 3'd7, '0, '0, "R10");
    chk("R10", "final", tos_data, 16'd36);
    chk("R10", "depth one", W'(depth), 16'd1);
    step(1, 3'd4, '0, '0, "R5");
    step(1, 3'd3, '0, '0, "R4");
    chk("R4", "out 36", out_data, 16'd36);
    // R8 underflow on empty and on short operator
    step(1, 3'd3, '0, '0, "R8");
    step(1, 3'd4, '0, '0, "R8");
    step(1, 3'd2, '0, 16'h1234, "R2");
    step(1, 3'd5, '0, '0, "R8");
    step(1, 3'd3, '0, '0, "R4");
    // R2 zero-extended immediate
    step(1, 3'd1, 8'hAB, 16'hFFFF, "R2");
    chk("R2", "imm zext", tos_data, 16'h00AB);
    // R7 wrap: 0xAB - 0xFFF0, then multiply wrap
    step(1, 3'd2, '0, 16'hFFF0, "R7");
    step(1, 3'd6, '0, '0, "R7");
    chk("R7", "sub wrap", tos_data, 16'h00BB);
    step(1, 3'd2, '0, 16'h8001, "R7");
    step(1, 3'd7, '0, '0, "R7");
    chk("R7", "mul low", tos_data, 16'h80BB);
    step(1, 3'd3, '0, '0, "R4");
    // R3 fill then overflow
    for (int i = 0; i < DEPTH; i++) step(1, 3'd2, '0, W'(i * 17 + 5), "R3");
    step(1, 3'd2, '0, 16'hDEAD, "R3");
    step(1, 3'd1, 8'h11, '0, "R3");
    chk("R3", "tos kept", tos_data, W'((DEPTH - 1) * 17 + 5));
    // R9 idle with push opcode, and opcode 0
    step(0, 3'd2, '0, 16'hBEEF, "R9");
    step(1, 3'd0, '0, 16'hBEEF, "R9");
    // R9 back-to-back random stream
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] op;
      int r;
      r = int'($urandom % 100);
      if (m_depth < 2 && r < 60)            op = 3'(1 + ($urandom % 2));
      else if (m_depth > DEPTH - 2 && r < 60) op = 3'(3 + ($urandom % 5));
      else                                  op = 3'($urandom % 8);
      step(($urandom % 10) != 0, op, 8'($urandom), 16'($urandom), "");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule